// File: doc/BRIEF.md
# Digit-Serial Signed Decimal Subtractor

This block subtracts one signed decimal number from another where both numbers live in a character memory. A start pulse carries three values: a length N, the address of the minuend's low-order character, and the address of the subtrahend's low-order character. Both operands are N characters long. The engine walks both operands from the low-order digit to the high-order digit, one digit at a time. It writes each result digit back over the minuend, so the difference replaces the minuend in place. The subtrahend is only read.

Each 6-bit character holds one BCD digit in bits 3..0 and two zone bits in bits 5..4. Bit 5 of the low-order character is the operand's sign. When the signs are equal the magnitudes are subtracted. When they differ the magnitudes are added.

When equal signs leave a final borrow, the stored value is the complement of the true magnitude. A second low-to-high pass then replaces it with its ten's complement and inverts the sign. A carry out of the top digit of a sum is counted in the zone bits of the top result character and raises sticky overflow indicators. A carry that the indicators can no longer record halts the engine with an alarm.

The parameter `TWO_IND` selects between two overflow configurations:
- a single indicator, with bit 4 of the top character as the only overflow bit;
- two indicators (the default), with bits 5..4 of the top character counting like a 2-bit binary counter.

The requirements below describe the default two-indicator configuration.

Top module: `dec_serial_sub`

## Requirements
- R1: A start with N = 0 raises `done` for one cycle on the next cycle. It makes no memory access and changes no indicator.
- R2: For N > 0 the engine spends three cycles per digit: read the minuend at A, read the subtrahend at B, write the result to A. It then steps both addresses down by one. `done` is first seen 3N+1 clock edges after the start edge when no complement pass is needed. Exactly N writes occur, and the subtrahend characters are left unchanged.
- R3: When both signs are equal and |minuend| >= |subtrahend|, the stored magnitude is |minuend| - |subtrahend| and the stored sign is the minuend's sign.
- R4: When the signs differ, the stored magnitude is |minuend| + |subtrahend| modulo 10^N, and the stored sign is the minuend's sign.
- R5: Character format: bits 3..0 are a BCD digit and bits 5..4 are zone bits. Bit 5 of the low-order character is the sign (1 = negative). For N > 1 the result's low-order character carries only the sign in its zone. The top result character keeps the minuend's top zone bits, plus any carry (see R6). Middle characters have zone 00.
- R6: A carry out of the top digit of a sum adds one to the 2-bit zone field of the top result character and sets overflow indicator 1 (`ovf1`).
- R7: If that carry meets a top zone whose bit 4 is already 1, it also sets overflow indicator 2 (`ovf2`).
- R8: A carry out of the top digit while `ovf2` is already set raises `alarm` and `done`, and the top character is not written. Every later start is ignored until reset.
- R9: When both signs are equal and |subtrahend| > |minuend|, a second pass of 2N cycles follows. It stores |subtrahend| - |minuend| with the sign opposite to the minuend's. `done` is first seen 5N+1 edges after the start edge.
- R10: With N = 1, a 1 in bit 4 of either operand raises `alarm` and `done` 4 edges after the start edge, without any write.
- R11: Reset clears `ovf1`, `ovf2`, `alarm`, `busy` and `done`. The indicators are sticky and stay set across later operations until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| start_len | input | LEN_W | Operand length N in characters |
| start_a | input | ADDR_W | Address of the minuend's low-order character |
| start_b | input | ADDR_W | Address of the subtrahend's low-order character |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation or on an alarm |
| mem_addr | output | ADDR_W | Memory address |
| mem_re | output | 1 | Read strobe; data is returned on `mem_rdata` one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 6 | Write data |
| mem_rdata | input | 6 | Read data |
| ovf1 | output | 1 | Sticky overflow indicator 1 |
| ovf2 | output | 1 | Sticky overflow indicator 2 |
| alarm | output | 1 | Alarm stop; held until reset |

## Verification
The assertions assume the following about the inputs:
- every digit read from memory is a valid BCD value from 0 to 9;
- the two operand fields do not overlap;
- no new start arrives while the engine is busy.

The output-digit property depends on the first of these assumptions. The bench's memory model only ever holds characters it built from digits 0 to 9. It places the operands at fixed, disjoint addresses, and it issues each start only after the previous `done`. Zone bits are set only where the requirements allow them: the sign bit of the low-order character, the minuend's top zone in the overflow cases, and bit 4 of a single-character operand in the alarm case.

// File: rtl/dsub_pkg.sv
package dsub_pkg;

    localparam int CHAR_W = 6;
    localparam int DIG_W  = 4;

    typedef struct packed {
        logic [1:0] zone;
        logic [3:0] dig;
    } dchar_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDA,
        ST_RDB,
        ST_WR,
        ST_CRD,
        ST_CWR,
        ST_HALT
    } dsub_st_e;

    // Returns {carry_out, digit} for x + y + ci.
    function automatic logic [4:0] bcd_add(input logic [3:0] x, input logic [3:0] y,
                                           input logic ci);
        logic [4:0] s;
        s = {1'b0, x} + {1'b0, y} + {4'b0, ci};
        if (s > 5'd9) return {1'b1, 4'(s - 5'd10)};
        return {1'b0, s[3:0]};
    endfunction

    // Returns {borrow_out, digit} for x - y - bi.
    function automatic logic [4:0] bcd_sub(input logic [3:0] x, input logic [3:0] y,
                                           input logic bi);
        logic [4:0] t;
        t = {1'b0, x} + 5'd10 - {1'b0, y} - {4'b0, bi};
        if (t >= 5'd10) return {1'b0, 4'(t - 5'd10)};
        return {1'b1, t[3:0]};
    endfunction

endpackage

// File: rtl/dsub_digit_alu.sv
module dsub_digit_alu
    import dsub_pkg::*;
(
    input  logic             sub,
    input  logic [DIG_W-1:0] x,
    input  logic [DIG_W-1:0] y,
    input  logic             ci,
    output logic [DIG_W-1:0] dig,
    output logic             co
);
    logic [4:0] r;

    always_comb begin
        if (sub) r = bcd_sub(x, y, ci);
        else     r = bcd_add(x, y, ci);
    end

    assign co  = r[4];
    assign dig = r[3:0];
endmodule

// File: rtl/dsub_zone_unit.sv
module dsub_zone_unit #(
    parameter bit TWO_IND = 1'b1
) (
    input  logic       is_lsd,
    input  logic       is_msd,
    input  logic       add_op,
    input  logic       cout,
    input  logic       sign_res,
    input  logic [1:0] a_zone,
    input  logic       b_bit4,
    input  logic       ovf1_q,
    input  logic       ovf2_q,
    output logic [1:0] zone_out,
    output logic       set1,
    output logic       set2,
    output logic       alarm_now
);
    logic ovf_c;
    logic single;
    logic [1:0] top_zone;

    assign ovf_c  = add_op & cout & is_msd;
    assign single = is_lsd & is_msd;
    assign set1   = ovf_c;

    generate
        if (TWO_IND) begin : g_two
            assign top_zone  = a_zone + {1'b0, ovf_c};
            assign set2      = ovf_c & ~is_lsd & a_zone[0];
            assign alarm_now = (single & (a_zone[0] | b_bit4)) | (ovf_c & ovf2_q);
        end else begin : g_one
            assign top_zone  = {1'b0, a_zone[0] | ovf_c};
            assign set2      = 1'b0;
            assign alarm_now = ovf_c & ovf1_q;
        end
    endgenerate

    always_comb begin
        if (single)      zone_out = {sign_res, ovf_c};
        else if (is_lsd) zone_out = {sign_res, 1'b0};
        else if (is_msd) zone_out = top_zone;
        else             zone_out = 2'b00;
    end
endmodule

// File: rtl/dec_serial_sub.sv
module dec_serial_sub
    import dsub_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int MAX_LEN = 44,
    parameter bit TWO_IND = 1'b1,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [ADDR_W-1:0] start_a,
    input  logic [ADDR_W-1:0] start_b,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [CHAR_W-1:0] mem_wdata,
    input  logic [CHAR_W-1:0] mem_rdata,
    output logic              ovf1,
    output logic              ovf2,
    output logic              alarm
);
    dsub_st_e          st;
    logic [ADDR_W-1:0] a_ptr, b_ptr, a_lsd;
    logic [LEN_W-1:0]  cnt, len_q;
    logic              first, carry, like_q, sign_a_q;
    dchar_t            a_chr;
    logic              done_q, alarm_q, ovf1_q, ovf2_q;

    dchar_t            rd;
    logic              eff_like, eff_sign, is_msd, in_cwr;
    logic [DIG_W-1:0]  alu_x, alu_dig;
    logic              alu_sub, alu_co;
    logic [1:0]        zu_zone;
    logic              zu_set1, zu_set2, zu_alarm;

    assign rd       = dchar_t'(mem_rdata);
    assign eff_like = first ? (a_chr.zone[1] == rd.zone[1]) : like_q;
    assign eff_sign = first ? a_chr.zone[1] : sign_a_q;
    assign is_msd   = (cnt == LEN_W'(1));
    assign in_cwr   = (st == ST_CWR);
    assign alu_sub  = in_cwr | eff_like;
    assign alu_x    = in_cwr ? '0 : a_chr.dig;

    dsub_digit_alu u_alu (
        .sub (alu_sub),
        .x   (alu_x),
        .y   (rd.dig),
        .ci  (carry),
        .dig (alu_dig),
        .co  (alu_co)
    );

    dsub_zone_unit #(.TWO_IND(TWO_IND)) u_zone (
        .is_lsd    (first),
        .is_msd    (is_msd),
        .add_op    (~eff_like),
        .cout      (alu_co),
        .sign_res  (eff_sign),
        .a_zone    (a_chr.zone),
        .b_bit4    (rd.zone[0]),
        .ovf1_q    (ovf1_q),
        .ovf2_q    (ovf2_q),
        .zone_out  (zu_zone),
        .set1      (zu_set1),
        .set2      (zu_set2),
        .alarm_now (zu_alarm)
    );

    always_comb begin
        mem_re    = (st == ST_RDA) || (st == ST_RDB) || (st == ST_CRD);
        mem_addr  = (st == ST_RDB) ? b_ptr : a_ptr;
        mem_we    = ((st == ST_WR) && !zu_alarm) || in_cwr;
        if (in_cwr) mem_wdata = {rd.zone[1] ^ first, rd.zone[0], alu_dig};
        else        mem_wdata = {zu_zone, alu_dig};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            a_ptr    <= '0;
            b_ptr    <= '0;
            a_lsd    <= '0;
            cnt      <= '0;
            len_q    <= '0;
            first    <= 1'b0;
            carry    <= 1'b0;
            like_q   <= 1'b0;
            sign_a_q <= 1'b0;
            a_chr    <= '0;
            done_q   <= 1'b0;
            alarm_q  <= 1'b0;
            ovf1_q   <= 1'b0;
            ovf2_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (start_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            a_ptr <= start_a;
                            a_lsd <= start_a;
                            b_ptr <= start_b;
                            cnt   <= start_len;
                            len_q <= start_len;
                            first <= 1'b1;
                            carry <= 1'b0;
                            st    <= ST_RDA;
                        end
                    end
                end
                ST_RDA: st <= ST_RDB;
                ST_RDB: begin
                    a_chr <= dchar_t'(mem_rdata);
                    st    <= ST_WR;
                end
                ST_WR: begin
                    if (zu_alarm) begin
                        alarm_q <= 1'b1;
                        done_q  <= 1'b1;
                        st      <= ST_HALT;
                    end else begin
                        if (first) begin
                            like_q   <= eff_like;
                            sign_a_q <= eff_sign;
                        end
                        if (zu_set1) ovf1_q <= 1'b1;
                        if (zu_set2) ovf2_q <= 1'b1;
                        carry <= alu_co;
                        first <= 1'b0;
                        a_ptr <= a_ptr - ADDR_W'(1);
                        b_ptr <= b_ptr - ADDR_W'(1);
                        cnt   <= cnt - LEN_W'(1);
                        if (is_msd) begin
                            if (eff_like && alu_co) begin
                                a_ptr <= a_lsd;
                                cnt   <= len_q;
                                carry <= 1'b0;
                                first <= 1'b1;
                                st    <= ST_CRD;
                            end else begin
                                done_q <= 1'b1;
                                st     <= ST_IDLE;
                            end
                        end else begin
                            st <= ST_RDA;
                        end
                    end
                end
                ST_CRD: st <= ST_CWR;
                ST_CWR: begin
                    carry <= alu_co;
                    first <= 1'b0;
                    a_ptr <= a_ptr - ADDR_W'(1);
                    cnt   <= cnt - LEN_W'(1);
                    if (is_msd) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_CRD;
                    end
                end
                default: st <= ST_HALT;
            endcase
        end
    end

    assign busy  = (st != ST_IDLE) && (st != ST_HALT);
    assign done  = done_q;
    assign alarm = alarm_q;
    assign ovf1  = ovf1_q;
    assign ovf2  = ovf2_q;

    // R1: zero length finishes at once
    p_zero_len_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start && start_len == '0) |=> (done && !busy));

    // R2: the next digit's minuend address is one below the one just written
    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WR && mem_we && !is_msd) |=> (mem_addr == $past(mem_addr) - ADDR_W'(1)));

    // R5: written digits stay BCD (assumes BCD inputs)
    p_bcd_out_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata[3:0] <= 4'd9));

    // R7: indicator 2 is never set without indicator 1
    p_ovf2_needs_ovf1_r7: assert property (@(posedge clk) disable iff (rst)
        ovf2 |-> ovf1);

    // R8: a halted engine neither writes nor reports busy
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        alarm |-> (!mem_we && !busy));

    // R11: indicators are sticky
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        ovf1 |=> ovf1);
endmodule

// File: tb/sim_dec_serial_sub.sv
module sim_dec_serial_sub;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 6;
    localparam int A_LSD  = 60;
    localparam int B_LSD  = 120;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  start_len = '0;
    logic [ADDR_W-1:0] start_a = '0, start_b = '0;
    logic              busy, done, mem_re, mem_we, ovf1, ovf2, alarm;
    logic [ADDR_W-1:0] mem_addr;
    logic [5:0]        mem_wdata;
    logic [5:0]        mem_rdata;

    logic [5:0]        mem [0:255];
    logic              tb_wr = 1'b0;
    logic [ADDR_W-1:0] tb_waddr = '0;
    logic [5:0]        tb_wdata = '0;
    int                wr_cnt = 0;

    int tests = 0, fails = 0;
    int ad [44];
    int bd [44];
    bit asg, bsg;
    logic [1:0] amz;
    logic [5:0] exp_ch [44];
    logic [5:0] b_img [44];
    int  exp_lat, lat, wr_before;
    bit  m_ovf1, m_ovf2;

    always #2 clk = ~clk;

    dec_serial_sub u0 (
        .clk(clk), .rst(rst), .start(start), .start_len(start_len),
        .start_a(start_a), .start_b(start_b), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ovf1(ovf1), .ovf2(ovf2), .alarm(alarm)
    );

    always_ff @(posedge clk) begin
        if (tb_wr) mem[tb_waddr] <= tb_wdata;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) wr_cnt <= wr_cnt + 1;
    end

    task automatic check(input string req, input bit ok, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic put(input int addr, input logic [5:0] v);
        @(negedge clk);
        tb_wr = 1'b1; tb_waddr = ADDR_W'(addr); tb_wdata = v;
        @(posedge clk);
    endtask

    task automatic setup(input int n);
        for (int i = 0; i < n; i++) begin
            logic [5:0] ca, cb;
            ca = 6'(ad[i]);
            cb = 6'(bd[i]);
            if (i == 0) begin ca[5] = asg; cb[5] = bsg; end
            if (i == n - 1 && n > 1) ca[5:4] = amz;
            b_img[i] = cb;
            put(A_LSD - i, ca);
            put(B_LSD - i, cb);
        end
        @(negedge clk); tb_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        m_ovf1 = 0; m_ovf2 = 0;
    endtask

    task automatic run_op(input int n);
        @(negedge clk);
        wr_before = wr_cnt;
        start = 1'b1; start_len = LEN_W'(n);
        start_a = ADDR_W'(A_LSD); start_b = ADDR_W'(B_LSD);
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk); start = 1'b0;
        end while (!done && lat < 2000);
    endtask

    // Reference: schoolbook signed decimal arithmetic on the digit arrays.
    task automatic model(input int n);
        int r [44];
        int cy, cmp, br, t;
        bit like, rsign, comp;
        like = (asg == bsg); cy = 0; comp = 0; rsign = asg;
        if (!like) begin
            for (int i = 0; i < n; i++) begin
                t = ad[i] + bd[i] + cy;
                r[i] = t % 10; cy = t / 10;
            end
        end else begin
            cmp = 0;
            for (int i = n - 1; i >= 0; i--)
                if (cmp == 0 && ad[i] != bd[i]) cmp = (ad[i] > bd[i]) ? 1 : -1;
            comp = (cmp < 0);
            if (comp) rsign = ~asg;
            br = 0;
            for (int i = 0; i < n; i++) begin
                t = comp ? (bd[i] - ad[i] - br) : (ad[i] - bd[i] - br);
                if (t < 0) begin t += 10; br = 1; end else br = 0;
                r[i] = t;
            end
        end
        for (int i = 0; i < n; i++) begin
            exp_ch[i] = 6'(r[i]);
            if (i == 0) exp_ch[i][5] = rsign;
            if (n == 1) exp_ch[i][4] = cy[0];
            else if (i == n - 1) exp_ch[i][5:4] = amz + 2'(cy);
        end
        if (cy != 0) begin
            m_ovf1 = 1;
            if (n > 1 && amz[0]) m_ovf2 = 1;
        end
        exp_lat = 3 * n + 1 + (comp ? 2 * n : 0);
    endtask

    task automatic verify(input string req, input int n);
        int bad_a, bad_b, wa, wb;
        bad_a = 0; bad_b = 0; wa = 0; wb = 0;
        check({req, " latency"}, lat == exp_lat, lat, exp_lat);
        for (int i = 0; i < n; i++) begin
            if (mem[A_LSD - i] !== exp_ch[i] && bad_a == 0) begin
                bad_a = 1; wa = i;
            end
            if (mem[B_LSD - i] !== b_img[i] && bad_b == 0) begin
                bad_b = 1; wb = i;
            end
        end
        check({req, " result chars"}, bad_a == 0, int'(mem[A_LSD - wa]), int'(exp_ch[wa]));
        check("R2 subtrahend intact", bad_b == 0, int'(mem[B_LSD - wb]), int'(b_img[wb]));
        check("R2 write count", (wr_cnt - wr_before) == n + ((exp_lat > 3 * n + 1) ? n : 0),
              wr_cnt - wr_before, n);
        check({req, " ovf1"}, ovf1 == m_ovf1, int'(ovf1), int'(m_ovf1));
        check({req, " ovf2"}, ovf2 == m_ovf2, int'(ovf2), int'(m_ovf2));
        check({req, " no alarm"}, alarm == 1'b0, int'(alarm), 0);
    endtask

    task automatic set_num(input int n, input longint av, input longint bv);
        longint x, y;
        x = av; y = bv;
        for (int i = 0; i < 44; i++) begin
            ad[i] = (i < n) ? int'(x % 10) : 0;
            bd[i] = (i < n) ? int'(y % 10) : 0;
            x = x / 10; y = y / 10;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_ovf1 = 0; m_ovf2 = 0; amz = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 reset state", {busy, done, ovf1, ovf2, alarm, mem_we} == 6'b0,
              int'({busy, done, ovf1, ovf2, alarm, mem_we}), 0);

        // R1 zero length
        run_op(0);
        check("R1 latency", lat == 1, lat, 1);
        check("R1 no writes", wr_cnt == wr_before, wr_cnt - wr_before, 0);

        // R3: +532 - +211
        set_num(3, 532, 211); asg = 0; bsg = 0; amz = 0;
        setup(3); model(3); run_op(3); verify("R3", 3);

        // R9: +211 - +532 => -321 through the complement pass
        set_num(3, 211, 532); asg = 0; bsg = 0;
        setup(3); model(3); run_op(3); verify("R9", 3);

        // R9 single digit: -3 - -8 => +5
        set_num(1, 3, 8); asg = 1; bsg = 1;
        setup(1); model(1); run_op(1); verify("R9", 1);

        // R5 full length: -(all 9) - -(all 1) => -(all 8)
        for (int i = 0; i < 44; i++) begin ad[i] = 9; bd[i] = 1; end
        asg = 1; bsg = 1;
        setup(44); model(44); run_op(44); verify("R5", 44);

        // R3 equal magnitudes give zero with the minuend's sign
        set_num(4, 7070, 7070); asg = 1; bsg = 1;
        setup(4); model(4); run_op(4); verify("R3", 4);

        // Random mix
        for (int k = 0; k < 40; k++) begin
            int n;
            n = 1 + int'($urandom % 18);
            for (int i = 0; i < 44; i++) begin
                ad[i] = (i < n) ? int'($urandom % 10) : 0;
                bd[i] = (i < n) ? int'($urandom % 10) : 0;
            end
            asg = $urandom % 2; bsg = $urandom % 2; amz = 0;
            setup(n); model(n);
            run_op(n);
            verify((asg == bsg) ? "R3" : "R4", n);
        end

        // R6: +75 - -48 => 123, carry into the top zone
        do_reset();
        set_num(2, 75, 48); asg = 0; bsg = 1; amz = 0;
        setup(2); model(2); run_op(2); verify("R6", 2);

        // R11: a later operation without carry leaves ovf1 set
        set_num(2, 50, 20); asg = 0; bsg = 0; amz = 0;
        setup(2); model(2); run_op(2); verify("R11", 2);

        // R7: top zone bit 4 already 1 plus a carry => zone 10, ovf2
        set_num(2, 75, 45); asg = 0; bsg = 1; amz = 2'b01;
        setup(2); model(2); run_op(2); verify("R7", 2);

        // R8: another carry with ovf2 set => alarm, top character kept
        set_num(2, 75, 45); asg = 0; bsg = 1; amz = 2'b00;
        setup(2); run_op(2);
        check("R8 latency", lat == 7, lat, 7);
        check("R8 alarm", alarm == 1'b1, int'(alarm), 1);
        check("R8 top char kept", mem[A_LSD - 1] == 6'h07, int'(mem[A_LSD - 1]), 7);
        check("R8 low char written", mem[A_LSD] == 6'h00, int'(mem[A_LSD]), 0);
        check("R8 one write", (wr_cnt - wr_before) == 1, wr_cnt - wr_before, 1);
        run_op(3);
        check("R8 start ignored", !busy && (wr_cnt == wr_before), wr_cnt - wr_before, 0);

        // R10: single character with bit 4 in the subtrahend
        do_reset();
        put(A_LSD, 6'h03); put(B_LSD, 6'h12);
        @(negedge clk); tb_wr = 1'b0;
        run_op(1);
        check("R10 latency", lat == 4, lat, 4);
        check("R10 alarm", alarm == 1'b1, int'(alarm), 1);
        check("R10 no write", (wr_cnt == wr_before) && mem[A_LSD] == 6'h03,
              int'(mem[A_LSD]), 3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule